// File: doc/BRIEF.md
# VLAN Membership Table Engine

This block holds a small VLAN membership table behind a register window. Software places an entry in a set of staging registers: a 13-bit VLAN ID with a valid flag, a 2-bit member code for each port, and an 8-bit filtering database number. It then writes the command register with the start bit and an opcode. The engine works through the table one entry per clock while the start bit reads back as busy. When the command completes, busy clears.

Three commands exist. Flush empties the table. Load/Purge adds, overwrites or removes the entry named by the staging VID. Next-entry search finds the smallest active VID above the VID now in the staging register. It writes that entry back into the staging registers, so software can walk the whole table by issuing the command repeatedly without reloading a cursor. A separate lookup port gives the membership and database number for any VID in the same cycle, for use by the forwarding logic.

A controller state machine has six states. `S_IDLE` waits for an accepted command. From it, `start_flush` goes to `S_FLUSH`, `start_load` goes to `S_LOAD_SCAN`, and `start_next` goes to `S_NEXT_SCAN`. `S_FLUSH` clears one slot per clock and returns to `S_IDLE` on `flush_done` after the last slot. `S_LOAD_SCAN` inspects one slot per clock, noting a slot whose VID matches and the first empty slot. It moves to `S_LOAD_COMMIT` on `load_scanned` and then returns on `load_written`. `S_NEXT_SCAN` tracks the best candidate. It moves to `S_NEXT_DONE` on `next_scanned`, and `S_NEXT_DONE` returns on `next_reported` after updating the staging registers.

Top module: `vlan_tbl_engine`

## Requirements
- R1: Writing address 0 with bit 15 set and opcode bits 14:12 equal to 1 (flush), 2 (load/purge) or 3 (next-entry search) starts a command. Bit 15 of address 0 reads 1 from the next clock until completion, which takes at least one clock per table slot, then reads 0.
- R2: While busy, host writes to any address are ignored: staging contents stay as they were, and a command write during busy starts nothing.
- R3: Address 1 holds VID bits 11:0 in bits 11:0, VID bit 12 in bit 12, and the valid flag in bit 13. Bits 15:14 read 0.
- R4: Port p's member code is at bits 4*(p mod 4)+1 : 4*(p mod 4) of address 2 + p/4. All other bits of these registers read 0.
- R5: The database number is split in address 0: its bits 3:0 are at bits 3:0 and its bits 7:4 are at bits 11:8. Bits 7:5 read 0.
- R6: Load/purge with valid=1 stores the staged members and database number under the staged VID, overwriting an existing entry for that VID.
- R7: Load/purge with valid=0 removes the entry for the staged VID, if there is one.
- R8: Next-entry search loads the lowest active VID strictly greater than the staged VID into address 1 with valid=1, and loads that entry's members and database number into the staging registers.
- R9: When no higher active VID exists, the search sets address 1 to VID 0x1FFF with valid=0. A staged VID of 0x1FFF makes the next search start from the lowest active VID.
- R10: Flush removes every entry and clears the full flag.
- R11: A load of a new VID into a table whose slots are all used leaves the table unchanged and sets bit 4 of address 0. That flag stays set until a flush.
- R12: For any `lk_vid`, `lk_hit` shows whether an active entry exists for it, and `lk_mem`/`lk_fdb` give that entry's contents in the same cycle. At most one slot matches any VID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_we | input | 1 | Host write strobe |
| hst_addr | input | 3 | Host register address |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data (combinational on address) |
| lk_vid | input | 13 | Lookup VID |
| lk_hit | output | 1 | Lookup found an active entry |
| lk_fdb | output | 8 | Database number of the found entry |
| lk_mem | output | 22 | Member codes of the found entry, 2 bits per port |

## Verification
On every cycle the embedded properties check several invariants. Busy rises only after an accepted command, and no command is accepted while busy. The staging registers do not move during a command except on the result write. A failed search always leaves the end marker. The full flag is sticky. A purge write really clears its slot. No VID ever matches two slots. The ordering of the search results, the bit packing of member codes and database number, the overwrite, purge and full-table outcomes, and the wrap from the end marker can only be shown by the bench scenarios. Those scenarios sweep the lookup port over all 8192 VIDs against a table model and walk the whole table with repeated searches.

// File: rtl/vtbl_pkg.sv
package vtbl_pkg;
    localparam int VID_W = 13;
    localparam int FDB_W = 8;
    localparam int ADR_OP  = 0;
    localparam int ADR_VID = 1;
    localparam int ADR_D0  = 2;

    localparam logic [2:0] OPC_FLUSH = 3'd1;
    localparam logic [2:0] OPC_LOAD  = 3'd2;
    localparam logic [2:0] OPC_NEXT  = 3'd3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FLUSH,
        S_LOAD_SCAN,
        S_LOAD_COMMIT,
        S_NEXT_SCAN,
        S_NEXT_DONE
    } state_t;
endpackage

// File: rtl/vtbl_store.sv
module vtbl_store
    import vtbl_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int NPORT = 11,
    localparam int IW = $clog2(DEPTH),
    localparam int MW = 2 * NPORT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic             wr_valid,
    input  logic [VID_W-1:0] wr_vid,
    input  logic [FDB_W-1:0] wr_fdb,
    input  logic [MW-1:0]    wr_mem,
    input  logic [IW-1:0]    rd_idx,
    output logic             rd_valid,
    output logic [VID_W-1:0] rd_vid,
    output logic [FDB_W-1:0] rd_fdb,
    output logic [MW-1:0]    rd_mem,
    input  logic [VID_W-1:0] lk_vid,
    output logic             lk_hit,
    output logic [FDB_W-1:0] lk_fdb,
    output logic [MW-1:0]    lk_mem
);
    logic [DEPTH-1:0] ent_v;
    logic [VID_W-1:0] ent_vid [DEPTH];
    logic [FDB_W-1:0] ent_fdb [DEPTH];
    logic [MW-1:0]    ent_mem [DEPTH];
    logic [DEPTH-1:0] hit;

    // Valid bits carry reset; payload is only meaningful under a valid bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_v <= '0;
        end else if (wr_en) begin
            ent_v[wr_idx] <= wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && wr_valid) begin
            ent_vid[wr_idx] <= wr_vid;
            ent_fdb[wr_idx] <= wr_fdb;
            ent_mem[wr_idx] <= wr_mem;
        end
    end

    assign rd_valid = ent_v[rd_idx];
    assign rd_vid   = ent_vid[rd_idx];
    assign rd_fdb   = ent_fdb[rd_idx];
    assign rd_mem   = ent_mem[rd_idx];

    // One comparator per slot for the lookup port.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit[g] = ent_v[g] && (ent_vid[g] == lk_vid);
    end

    always_comb begin
        lk_fdb = '0;
        lk_mem = '0;
        for (int e = 0; e < DEPTH; e++) begin
            if (hit[e]) begin
                lk_fdb = lk_fdb | ent_fdb[e];
                lk_mem = lk_mem | ent_mem[e];
            end
        end
    end
    assign lk_hit = |hit;

    // R12: a VID never resides in two slots
    a_r12_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R7: a clearing write leaves its slot inactive
    a_r7_purge_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_valid) |=> !ent_v[$past(wr_idx)]);
endmodule

// File: rtl/vtbl_stage.sv
module vtbl_stage
    import vtbl_pkg::*;
#(
    parameter int NPORT = 11,
    parameter int AW = 3,
    localparam int MW = 2 * NPORT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hst_we,
    input  logic [AW-1:0]    hst_addr,
    input  logic [15:0]      hst_wdata,
    output logic [15:0]      hst_rdata,
    input  logic             busy,
    input  logic             full,
    input  logic             res_we,
    input  logic             res_valid,
    input  logic [VID_W-1:0] res_vid,
    input  logic [FDB_W-1:0] res_fdb,
    input  logic [MW-1:0]    res_mem,
    output logic             go,
    output logic [2:0]       go_op,
    output logic             stg_valid,
    output logic [VID_W-1:0] stg_vid,
    output logic [FDB_W-1:0] stg_fdb,
    output logic [MW-1:0]    stg_mem
);
    logic             wr_ok;
    logic [2:0]       op_q;
    logic [FDB_W-1:0] fdb_q;
    logic [VID_W-1:0] vid_q;
    logic             vld_q;
    logic [MW-1:0]    mem_q;

    assign wr_ok = hst_we && !busy;
    assign go_op = hst_wdata[14:12];
    assign go    = wr_ok && (hst_addr == AW'(ADR_OP)) && hst_wdata[15]
                   && ((go_op == OPC_FLUSH) || (go_op == OPC_LOAD) || (go_op == OPC_NEXT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= '0;
            fdb_q <= '0;
            vid_q <= '0;
            vld_q <= 1'b0;
            mem_q <= '0;
        end else if (res_we) begin
            vid_q <= res_vid;
            vld_q <= res_valid;
            if (res_valid) begin
                fdb_q <= res_fdb;
                mem_q <= res_mem;
            end
        end else if (wr_ok) begin
            if (hst_addr == AW'(ADR_OP)) begin
                op_q  <= hst_wdata[14:12];
                fdb_q <= {hst_wdata[11:8], hst_wdata[3:0]};
            end
            if (hst_addr == AW'(ADR_VID)) begin
                vid_q <= hst_wdata[12:0];
                vld_q <= hst_wdata[13];
            end
            for (int p = 0; p < NPORT; p++) begin
                if (hst_addr == AW'(ADR_D0 + p / 4)) begin
                    mem_q[2*p +: 2] <= hst_wdata[4*(p%4) +: 2];
                end
            end
        end
    end

    always_comb begin
        hst_rdata = '0;
        if (hst_addr == AW'(ADR_OP)) begin
            hst_rdata = {busy, op_q, fdb_q[7:4], 3'b000, full, fdb_q[3:0]};
        end else if (hst_addr == AW'(ADR_VID)) begin
            hst_rdata = {2'b00, vld_q, vid_q};
        end else begin
            for (int p = 0; p < NPORT; p++) begin
                if (hst_addr == AW'(ADR_D0 + p / 4)) begin
                    hst_rdata[4*(p%4) +: 2] = mem_q[2*p +: 2];
                end
            end
        end
    end

    assign stg_valid = vld_q;
    assign stg_vid   = vid_q;
    assign stg_fdb   = fdb_q;
    assign stg_mem   = mem_q;

    // R2: staging is frozen during a command apart from the result write
    a_r2_stage_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !res_we) |=> ($stable(vid_q) && $stable(vld_q) && $stable(mem_q) && $stable(fdb_q)));

    // R9: a fruitless search leaves the end marker
    a_r9_end_marker: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && !res_valid) |=> ((&vid_q) && !vld_q));
endmodule

// File: rtl/vtbl_ctrl.sv
module vtbl_ctrl
    import vtbl_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [2:0]       go_op,
    input  logic             stg_valid,
    input  logic [VID_W-1:0] stg_vid,
    input  logic             rd_valid,
    input  logic [VID_W-1:0] rd_vid,
    output logic [IW-1:0]    rd_idx,
    output logic             wr_en,
    output logic [IW-1:0]    wr_idx,
    output logic             wr_valid,
    output logic             busy,
    output logic             full,
    output logic             res_we,
    output logic             res_valid,
    output logic [VID_W-1:0] res_vid
);
    state_t           st_q, st_d;
    logic [IW-1:0]    idx_q;
    logic             last;
    logic             wrap;
    logic             hit_f_q, free_f_q, best_f_q;
    logic [IW-1:0]    hit_i_q, free_i_q, best_i_q;
    logic [VID_W-1:0] best_v_q;
    logic             full_q;

    assign last = (idx_q == IW'(DEPTH - 1));
    assign wrap = &stg_vid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (go && go_op == OPC_FLUSH)     st_d = S_FLUSH;      // start_flush
                else if (go && go_op == OPC_LOAD) st_d = S_LOAD_SCAN;  // start_load
                else if (go && go_op == OPC_NEXT) st_d = S_NEXT_SCAN;  // start_next
            end
            S_FLUSH:       if (last) st_d = S_IDLE;                    // flush_done
            S_LOAD_SCAN:   if (last) st_d = S_LOAD_COMMIT;             // load_scanned
            S_LOAD_COMMIT: st_d = S_IDLE;                              // load_written
            S_NEXT_SCAN:   if (last) st_d = S_NEXT_DONE;               // next_scanned
            S_NEXT_DONE:   st_d = S_IDLE;                              // next_reported
            default:       st_d = S_IDLE;
        endcase
    end

    // Scan bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            hit_f_q  <= 1'b0;
            free_f_q <= 1'b0;
            best_f_q <= 1'b0;
            hit_i_q  <= '0;
            free_i_q <= '0;
            best_i_q <= '0;
            best_v_q <= '0;
            full_q   <= 1'b0;
        end else begin
            if (st_q == S_IDLE) begin
                idx_q    <= '0;
                hit_f_q  <= 1'b0;
                free_f_q <= 1'b0;
                best_f_q <= 1'b0;
            end else if (st_q == S_FLUSH || st_q == S_LOAD_SCAN || st_q == S_NEXT_SCAN) begin
                idx_q <= idx_q + 1'b1;
            end
            if (st_q == S_LOAD_SCAN) begin
                if (rd_valid && rd_vid == stg_vid && !hit_f_q) begin
                    hit_f_q <= 1'b1;
                    hit_i_q <= idx_q;
                end
                if (!rd_valid && !free_f_q) begin
                    free_f_q <= 1'b1;
                    free_i_q <= idx_q;
                end
            end
            if (st_q == S_NEXT_SCAN && rd_valid && (wrap || rd_vid > stg_vid)
                && (!best_f_q || rd_vid < best_v_q)) begin
                best_f_q <= 1'b1;
                best_i_q <= idx_q;
                best_v_q <= rd_vid;
            end
            if (st_q == S_FLUSH) begin
                full_q <= 1'b0;
            end else if (st_q == S_LOAD_COMMIT && stg_valid && !hit_f_q && !free_f_q) begin
                full_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        busy      = (st_q != S_IDLE);
        full      = full_q;
        rd_idx    = (st_q == S_NEXT_DONE) ? best_i_q : idx_q;
        wr_en     = 1'b0;
        wr_idx    = idx_q;
        wr_valid  = 1'b0;
        res_we    = 1'b0;
        res_valid = 1'b0;
        res_vid   = '1;
        unique case (st_q)
            S_FLUSH: wr_en = 1'b1;
            S_LOAD_COMMIT: begin
                if (hit_f_q) begin
                    wr_en    = 1'b1;
                    wr_idx   = hit_i_q;
                    wr_valid = stg_valid;
                end else if (stg_valid && free_f_q) begin
                    wr_en    = 1'b1;
                    wr_idx   = free_i_q;
                    wr_valid = 1'b1;
                end
            end
            S_NEXT_DONE: begin
                res_we    = 1'b1;
                res_valid = best_f_q;
                if (best_f_q) res_vid = best_v_q;
            end
            default: ;
        endcase
    end

    // R1: busy rises only for an accepted command
    a_r1_busy_from_go: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go));

    // R2: no command is accepted while one runs
    a_r2_no_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);

    // R11: full flag only drops during a flush
    a_r11_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && st_q != S_FLUSH) |=> full_q);
endmodule

// File: rtl/vlan_tbl_engine.sv
module vlan_tbl_engine
    import vtbl_pkg::*;
#(
    parameter int NPORT = 11,
    parameter int DEPTH = 64,
    parameter int AW    = 3,
    localparam int IW = $clog2(DEPTH),
    localparam int MW = 2 * NPORT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hst_we,
    input  logic [AW-1:0]    hst_addr,
    input  logic [15:0]      hst_wdata,
    output logic [15:0]      hst_rdata,
    input  logic [VID_W-1:0] lk_vid,
    output logic             lk_hit,
    output logic [FDB_W-1:0] lk_fdb,
    output logic [MW-1:0]    lk_mem
);
    logic             busy, full, go;
    logic [2:0]       go_op;
    logic             stg_valid;
    logic [VID_W-1:0] stg_vid;
    logic [FDB_W-1:0] stg_fdb;
    logic [MW-1:0]    stg_mem;
    logic             res_we, res_valid;
    logic [VID_W-1:0] res_vid;
    logic [IW-1:0]    rd_idx, wr_idx;
    logic             rd_valid, wr_en, wr_valid;
    logic [VID_W-1:0] rd_vid;
    logic [FDB_W-1:0] rd_fdb;
    logic [MW-1:0]    rd_mem;

    vtbl_stage #(.NPORT(NPORT), .AW(AW)) stage_i (
        .clk(clk), .rst_n(rst_n),
        .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .busy(busy), .full(full),
        .res_we(res_we), .res_valid(res_valid), .res_vid(res_vid),
        .res_fdb(rd_fdb), .res_mem(rd_mem),
        .go(go), .go_op(go_op),
        .stg_valid(stg_valid), .stg_vid(stg_vid), .stg_fdb(stg_fdb), .stg_mem(stg_mem)
    );

    vtbl_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .go(go), .go_op(go_op),
        .stg_valid(stg_valid), .stg_vid(stg_vid),
        .rd_valid(rd_valid), .rd_vid(rd_vid), .rd_idx(rd_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .busy(busy), .full(full),
        .res_we(res_we), .res_valid(res_valid), .res_vid(res_vid)
    );

    vtbl_store #(.DEPTH(DEPTH), .NPORT(NPORT)) store_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_vid(stg_vid), .wr_fdb(stg_fdb), .wr_mem(stg_mem),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_vid(rd_vid),
        .rd_fdb(rd_fdb), .rd_mem(rd_mem),
        .lk_vid(lk_vid), .lk_hit(lk_hit), .lk_fdb(lk_fdb), .lk_mem(lk_mem)
    );
endmodule

// File: tb/vlan_tbl_engine_tb_top.sv
`timescale 1ns/1ps
module vlan_tbl_engine_tb_top;
    localparam int NP = 11;
    localparam int DP = 64;
    localparam int MW = 2 * NP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hst_we = 1'b0;
    logic [2:0]    hst_addr = '0;
    logic [15:0]   hst_wdata = '0;
    logic [15:0]   hst_rdata;
    logic [12:0]   lk_vid = '0;
    logic          lk_hit;
    logic [7:0]    lk_fdb;
    logic [MW-1:0] lk_mem;

    always #4 clk = ~clk;

    vlan_tbl_engine #(.NPORT(NP), .DEPTH(DP), .AW(3)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .lk_vid(lk_vid), .lk_hit(lk_hit), .lk_fdb(lk_fdb), .lk_mem(lk_mem)
    );

    int n_chk = 0;
    int n_err = 0;
    bit            mv [8192];
    logic [MW-1:0] mm [8192];
    logic [7:0]    mf [8192];
    int            mcount = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pack(input logic [MW-1:0] m, input int r);
        logic [15:0] v = '0;
        for (int p = 0; p < NP; p++)
            if (p / 4 == r) v[4*(p%4) +: 2] = m[2*p +: 2];
        return v;
    endfunction

    function automatic int next_of(input int cur);
        int s = (cur == 8191) ? 0 : cur + 1;
        for (int v = s; v < 8192; v++) if (mv[v]) return v;
        return -1;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        hst_we = 1'b1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        hst_addr = a;
        #1 d = hst_rdata;
    endtask

    task automatic wait_idle(output int cyc);
        logic [15:0] v;
        cyc = 0;
        do begin
            rd(3'd0, v);
            cyc++;
        end while (v[15] && cyc < 5000);
    endtask

    // Write command word; check busy immediately after the accepting edge (R1)
    task automatic issue(input logic [2:0] opc, input logic [7:0] fdb);
        wr(3'd0, {1'b1, opc, fdb[7:4], 4'h0, fdb[3:0]});
        hst_addr = 3'd0;
        #1 chk(hst_rdata[15] == 1'b1, "R1", "busy after command", hst_rdata[15], 1);
    endtask

    task automatic stage(input logic [12:0] vid, input bit vld, input logic [MW-1:0] m);
        wr(3'd1, {2'b00, vld, vid});
        for (int r = 0; r < 3; r++) wr(3'(2 + r), pack(m, r));
    endtask

    task automatic model_load(input int vid, input bit vld, input logic [MW-1:0] m,
                              input logic [7:0] f);
        if (vld) begin
            if (mv[vid] || mcount < DP) begin
                if (!mv[vid]) mcount++;
                mv[vid] = 1'b1; mm[vid] = m; mf[vid] = f;
            end
        end else if (mv[vid]) begin
            mv[vid] = 1'b0; mcount--;
        end
    endtask

    task automatic do_load(input int vid, input bit vld, input logic [MW-1:0] m,
                           input logic [7:0] f);
        int cyc;
        stage(13'(vid), vld, m);
        issue(3'd2, f);
        wait_idle(cyc);
        model_load(vid, vld, m, f);
    endtask

    task automatic sweep(input string req);
        int bad = 0;
        int first = -1;
        for (int v = 0; v < 8192; v++) begin
            @(negedge clk);
            lk_vid = 13'(v);
            #1;
            if (lk_hit !== mv[v] || (mv[v] && (lk_mem !== mm[v] || lk_fdb !== mf[v]))) begin
                bad++;
                if (first < 0) first = v;
            end
        end
        chk(bad == 0, req, "lookup sweep mismatches (first vid in expected)", bad, first);
    endtask

    // Search and compare staging against the model; returns found vid or -1
    task automatic do_next(input int cursor, output int got);
        int cyc, e;
        logic [15:0] v;
        issue(3'd3, 8'h00);
        wait_idle(cyc);
        chk(cyc >= DP, "R1", "search length in clocks", cyc, DP);
        e = next_of(cursor);
        rd(3'd1, v);
        if (e >= 0) begin
            chk(v == {3'b001, 13'(e)}, "R8", "next vid register", v, {3'b001, 13'(e)});
            rd(3'd0, v);
            chk({v[11:8], v[3:0]} == mf[e] && v[7:5] == 3'b000, "R5", "fdb fields after search",
                {v[11:8], v[3:0]}, mf[e]);
            for (int r = 0; r < 3; r++) begin
                logic [15:0] d;
                rd(3'(2 + r), d);
                chk(d == pack(mm[e], r), "R4", "member register after search", d, pack(mm[e], r));
            end
            got = e;
        end else begin
            chk(v == 16'h1FFF, "R9", "end marker", v, 16'h1FFF);
            got = -1;
        end
    endtask

    initial begin
        #(8 * 190000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int got, cur, cyc;
        for (int i = 0; i < 8192; i++) begin mv[i] = 0; mm[i] = '0; mf[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        rd(3'd0, v); chk(v == 16'h0, "R1", "op reg at reset", v, 0);
        rd(3'd1, v); chk(v == 16'h0, "R3", "vid reg at reset", v, 0);
        #1 chk(lk_hit == 1'b0, "R12", "lookup at reset", lk_hit, 0);

        // R3: field layout
        wr(3'd1, 16'hFFFF); rd(3'd1, v); chk(v == 16'h3FFF, "R3", "vid all ones", v, 16'h3FFF);
        wr(3'd1, 16'h1ABC); rd(3'd1, v); chk(v == 16'h1ABC, "R3", "page bit no valid", v, 16'h1ABC);

        // R4: member packing masks
        for (int r = 0; r < 3; r++) begin
            logic [15:0] exp;
            exp = (r == 2) ? 16'h0333 : 16'h3333;
            wr(3'(2 + r), 16'hFFFF); rd(3'(2 + r), v);
            chk(v == exp, "R4", "data register mask", v, exp);
        end

        // R5: fdb split without start bit
        wr(3'd0, 16'h0A05); rd(3'd0, v); chk(v == 16'h0A05, "R5", "fdb split readback", v, 16'h0A05);

        // R6/R12: load a spread of entries including boundaries
        do_load(0,    1, 22'h155555, 8'h01);
        do_load(4095, 1, 22'h0F0F0F, 8'hA5);
        do_load(4096, 1, 22'h3FFFFF, 8'h5A);
        do_load(8190, 1, 22'h000003, 8'hFF);
        do_load(17,   1, 22'h123456, 8'h10);
        do_load(300,  1, 22'h2AAAAA, 8'h0F);
        stage(13'd50, 1, 22'h111111);
        issue(3'd2, 8'h77);
        wait_idle(cyc);
        chk(cyc >= DP, "R1", "load length in clocks", cyc, DP);
        model_load(50, 1, 22'h111111, 8'h77);
        sweep("R12");

        // R6 overwrite
        do_load(17, 1, 22'h0C0C0C, 8'h33);
        sweep("R6");

        // R8/R9: walk from end marker
        wr(3'd1, 16'h1FFF);
        cur = 8191;
        for (int k = 0; k < 12; k++) begin
            do_next(cur, got);
            if (got < 0) break;
            cur = got;
        end
        // R9: wrap after end marker
        do_next(8191, got);
        chk(got == 0, "R9", "restart from lowest", got, 0);
        // R8 from a middle cursor
        wr(3'd1, 16'd301);
        do_next(301, got);
        chk(got == 4095, "R8", "middle cursor", got, 4095);

        // R7 purge, plus purge of absent vid
        do_load(300, 0, '0, 8'h00);
        do_load(777, 0, '0, 8'h00);
        sweep("R7");

        // R2: writes while busy ignored
        stage(13'd100, 1, 22'h2C2C2C);
        issue(3'd2, 8'h42);
        wr(3'd1, 16'h2005);
        wr(3'd2, 16'h0000);
        wr(3'd0, 16'h9000);
        wait_idle(cyc);
        model_load(100, 1, 22'h2C2C2C, 8'h42);
        rd(3'd1, v); chk(v == 16'h2064, "R2", "vid reg after busy writes", v, 16'h2064);
        rd(3'd2, v); chk(v == pack(22'h2C2C2C, 0), "R2", "data reg after busy writes", v, pack(22'h2C2C2C, 0));
        rd(3'd0, v); chk(v[15] == 1'b0, "R2", "no command started during busy", v[15], 0);
        sweep("R2");

        // R10: flush
        issue(3'd1, 8'h00);
        wait_idle(cyc);
        chk(cyc >= DP, "R1", "flush length in clocks", cyc, DP);
        for (int i = 0; i < 8192; i++) mv[i] = 0;
        mcount = 0;
        sweep("R10");

        // R11: fill the table then overflow
        for (int i = 0; i < DP; i++) do_load(i * 37 + 5, 1, 22'(i * 12345), 8'(i));
        rd(3'd0, v); chk(v[4] == 1'b0, "R11", "full flag before overflow", v[4], 0);
        do_load(8000, 1, 22'h3FFFFF, 8'hEE);
        rd(3'd0, v); chk(v[4] == 1'b1, "R11", "full flag on overflow", v[4], 1);
        do_load(5, 1, 22'h000011, 8'h22);
        rd(3'd0, v); chk(v[4] == 1'b1, "R11", "full flag sticky", v[4], 1);
        sweep("R11");
        issue(3'd1, 8'h00);
        wait_idle(cyc);
        for (int i = 0; i < 8192; i++) mv[i] = 0;
        mcount = 0;
        rd(3'd0, v); chk(v[4] == 1'b0, "R10", "flush clears full flag", v[4], 0);
        wr(3'd1, 16'h1FFF);
        do_next(8191, got);
        chk(got == -1, "R10", "search on empty table", got, -1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule